// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two chained timeouts, reached through an APB register port and clocked by the bus clock. Software turns it on through a control register. A 32-bit up counter then measures a first delay, and when that delay expires the block raises an interrupt. The interrupt stays raised until software sends a fixed two-write service sequence to the restart register. If no service arrives before a second, separately chosen delay runs out, the block sends a one-cycle system reset request to the power management logic.

Each delay is a power of two picked by a 4-bit select. Select value n gives 2^(BASE_EXP+n) cycles, and BASE_EXP defaults to 16, so the range is 2^16 to 2^31 cycles. The select values are latched when the timer is enabled and again on each successful service. A select change written while the timer runs has no effect until the next restart. A status register reports whether the interrupt is pending and whether the first half of the service sequence has been seen.

The APB port has no wait states and no error response, so the block never applies back-pressure. A write takes effect on the access cycle, which is the cycle where psel, penable and pwrite are all high. Read data is valid during every read cycle. The interrupt and reset request outputs are plain level and pulse pins.

Top module: `wdt_top`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control), 0x4 (restart) and 0x8 (status). Control bits are: bit0 run, bit1 interrupt enable, bit2 reset enable, bits[6:3] interrupt delay select, bits[10:7] reset delay select. Control reads back these bits, and the other bits read 0. The restart register and unmapped offsets read 0. Status bit0 is interrupt pending and status bit1 is sequence armed.
- R2: After reset, control and status read 0, and both the interrupt and the reset request outputs are low.
- R3: Pending is set exactly 2^(BASE_EXP+int_sel) cycles after the access cycle that sets run, or after the access cycle that completes a service. The interrupt output equals pending gated by the interrupt enable.
- R4: Counting from the cycle pending is set, the reset request pulses high for exactly one cycle 2^(BASE_EXP+rst_sel) cycles later. After that pulse, no further request is issued until the next restart.
- R5: A write of 0xA5 to the restart register (low byte), followed directly by a restart write of 0x5A, clears pending and restarts the count from zero. Any other restart write value drops the armed state. Status bit1 is 1 only after 0xA5 was the last restart write.
- R6: Clearing run stops the count and clears pending one cycle after the access. Setting run again starts a full new interrupt delay.
- R7: A select change written while run is set takes effect only at the next restart.
- R8: With reset enable clear, no reset request is issued. With interrupt enable clear, the interrupt output stays low, but pending still shows in status and the reset delay still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| irq_o | output | 1 | Interrupt level to the CPU |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A counter that is off by one cycle moves the interrupt edge or the reset pulse by a single clock. The bench therefore samples these pins exactly one cycle early and exactly on time, for several select values. A sequence tracker that is stuck or leaks shows in the status armed bit right after the write that should have changed it, and also as an interrupt that clears when it should not, or that fails to clear. Latching a select at the wrong moment moves the first expiry after a select change by a whole power of two. Logic that re-arms or drops the reset stage shows within tens of cycles as an extra pulse or a missing pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W    = 4;
  localparam int NUM_TAPS = 1 << SEL_W;

  localparam logic [11:0] OFS_CTRL    = 12'h000;
  localparam logic [11:0] OFS_RESTART = 12'h004;
  localparam logic [11:0] OFS_STATUS  = 12'h008;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  // control register image, bit 0 at the bottom
  typedef struct packed {
    logic [SEL_W-1:0] rst_sel;   // [10:7]
    logic [SEL_W-1:0] int_sel;   // [6:3]
    logic             rst_en;    // [2]
    logic             irq_en;    // [1]
    logic             run;       // [0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    PH_INT  = 2'd0,
    PH_RST  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/wdt_apb_regs.sv
module wdt_apb_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output ctrl_t             ctrl,
  output logic              rs_wr,
  output logic [7:0]        rs_data,
  input  logic              pending,
  input  logic              armed
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RS   = ADDR_W'(OFS_RESTART);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

  logic wr_acc;
  logic rd_phase;
  logic unused_hi;

  assign wr_acc    = psel && penable && pwrite;
  assign rd_phase  = psel && !pwrite;
  assign unused_hi = ^pwdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_acc && paddr == A_CTRL) begin
      ctrl <= ctrl_t'(pwdata[CTRL_W-1:0]);
    end
  end

  assign rs_wr   = wr_acc && (paddr == A_RS);
  assign rs_data = pwdata[7:0];

  always_comb begin
    prdata = '0;
    if (rd_phase) begin
      if (paddr == A_CTRL)      prdata = DATA_W'(ctrl);
      else if (paddr == A_STAT) prdata = DATA_W'({armed, pending});
    end
  end
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rs_wr,
  input  logic [7:0] rs_data,
  output logic       armed,
  output logic       svc
);
  assign svc = rs_wr && armed && (rs_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n)     armed <= 1'b0;
    else if (rs_wr) armed <= (rs_data == KEY_FIRST);
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rst_en,
  input  logic [SEL_W-1:0] int_sel,
  input  logic [SEL_W-1:0] rst_sel,
  input  logic             svc,
  output logic             pending,
  output logic             rst_pulse
);
  logic [CNT_W-1:0] tap_lim [NUM_TAPS];
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] act_int;
  logic [SEL_W-1:0] act_rst;
  logic             live;
  phase_e           phase;

  // terminal count of each tap: 2^(BASE_EXP+g) - 1
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_lim[g] = (CNT_W'(1) << (BASE_EXP + g)) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_int   <= '0;
      act_rst   <= '0;
      live      <= 1'b0;
      phase     <= PH_INT;
      pending   <= 1'b0;
      rst_pulse <= 1'b0;
    end else if (!run) begin
      cnt       <= '0;
      live      <= 1'b0;
      phase     <= PH_INT;
      pending   <= 1'b0;
      rst_pulse <= 1'b0;
    end else if (!live) begin
      // first running cycle: capture selects, this cycle already counts
      live      <= 1'b1;
      act_int   <= int_sel;
      act_rst   <= rst_sel;
      cnt       <= CNT_W'(1);
      rst_pulse <= 1'b0;
    end else if (svc) begin
      act_int   <= int_sel;
      act_rst   <= rst_sel;
      cnt       <= '0;
      phase     <= PH_INT;
      pending   <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      unique case (phase)
        PH_INT: begin
          if (cnt == tap_lim[act_int]) begin
            cnt     <= '0;
            pending <= 1'b1;
            phase   <= PH_RST;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_RST: begin
          if (cnt == tap_lim[act_rst]) begin
            cnt       <= '0;
            rst_pulse <= rst_en;
            phase     <= PH_DONE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t      ctrl_q;
  logic       rs_wr;
  logic [7:0] rs_data;
  logic       armed;
  logic       svc;
  logic       pending;
  logic       ctrl_run;

  assign ctrl_run = ctrl_q.run;

  wdt_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ctrl(ctrl_q), .rs_wr(rs_wr), .rs_data(rs_data),
    .pending(pending), .armed(armed)
  );

  wdt_svc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rs_wr(rs_wr), .rs_data(rs_data),
    .armed(armed), .svc(svc)
  );

  wdt_core #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .rst_en(ctrl_q.rst_en),
    .int_sel(ctrl_q.int_sel), .rst_sel(ctrl_q.rst_sel), .svc(svc),
    .pending(pending), .rst_pulse(rst_req_o)
  );

  assign irq_o = pending && ctrl_q.irq_en;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic pending,
  input logic svc,
  input logic rst_req
);
  // R4
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4
  rst_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> pending);

  // R6
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pending);

  // R5
  svc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && run) |=> !pending);

  // R3
  rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(run));
endmodule

bind wdt_top wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_run), .pending(pending),
  .svc(svc), .rst_req(rst_req_o)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int BE = 3;   // taps of 8 << sel cycles

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          irq_o, rst_req_o;

  int total = 0;
  int bad   = 0;
  int rst_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_top #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(32), .BASE_EXP(BE)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (rst_req_o) rst_seen++;

  function automatic logic [31:0] cv(bit run, bit ie, bit re, int isel, int rsel);
    return 32'(run) | (32'(ie) << 1) | (32'(re) << 2) | (32'(isel) << 3) | (32'(rsel) << 7);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    @(posedge clk);
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk) begin penable = 1'b1; d = prdata; end
    @(posedge clk);
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic service();
    wr(12'h004, 32'hA5);
    wr(12'h004, 32'h5A);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 irq after reset", 32'(irq_o), 0);
    chk("R2 rst_req after reset", 32'(rst_req_o), 0);
    rd(12'h000, d); chk("R2 ctrl reset value", d, 0);
    rd(12'h008, d); chk("R2 status reset value", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h000, 32'hFFFF_FFFE);
    rd(12'h000, d); chk("R1 ctrl readback masked", d, 32'h7FE);
    rd(12'h004, d); chk("R1 restart reads zero", d, 0);
    rd(12'h00C, d); chk("R1 unmapped reads zero", d, 0);
    wr(12'h000, 0);
  endtask

  task automatic t_expiry();
    int r0;
    wr(12'h000, cv(1, 1, 1, 1, 0));      // 16 then 8 cycles
    cyc(15); chk("R3 irq one cycle early", 32'(irq_o), 0);
    cyc(1);  chk("R3 irq on time", 32'(irq_o), 1);
    r0 = rst_seen;
    cyc(7);  chk("R4 no reset request early", 32'(rst_seen - r0), 0);
    cyc(1);  chk("R4 reset request on time", 32'(rst_req_o), 1);
    cyc(1);  chk("R4 reset request one cycle wide", 32'(rst_req_o), 0);
    cyc(40); chk("R4 no second reset request", 32'(rst_seen - r0), 1);
    chk("R5 irq held until serviced", 32'(irq_o), 1);
    service();
    chk("R5 service clears irq", 32'(irq_o), 0);
    cyc(15); chk("R5 restart counts from zero (early)", 32'(irq_o), 0);
    cyc(1);  chk("R5 restart counts from zero (on time)", 32'(irq_o), 1);
    wr(12'h000, 0);
  endtask

  task automatic t_kick();
    wr(12'h000, cv(1, 1, 0, 1, 0));
    cyc(10);
    service();
    cyc(15); chk("R5 early kick restarts count (early)", 32'(irq_o), 0);
    cyc(1);  chk("R5 early kick restarts count (on time)", 32'(irq_o), 1);
    wr(12'h000, 0);
  endtask

  task automatic t_badseq();
    logic [31:0] d;
    int r0;
    r0 = rst_seen;
    wr(12'h000, cv(1, 1, 0, 0, 0));
    cyc(10);
    wr(12'h004, 32'h5A);
    rd(12'h008, d); chk("R5 lone second key ignored", d, 32'h1);
    wr(12'h004, 32'hA5);
    rd(12'h008, d); chk("R5 first key arms tracker", d, 32'h3);
    wr(12'h004, 32'h33);
    rd(12'h008, d); chk("R5 wrong value disarms", d, 32'h1);
    wr(12'h004, 32'h5A);
    chk("R5 broken sequence leaves irq", 32'(irq_o), 1);
    cyc(20);
    chk("R8 reset disabled gives no request", 32'(rst_seen - r0), 0);
    service();
    chk("R5 proper sequence clears irq", 32'(irq_o), 0);
    wr(12'h000, 0);
  endtask

  task automatic t_irq_masked();
    logic [31:0] d;
    int r0;
    r0 = rst_seen;
    wr(12'h000, cv(1, 0, 1, 0, 1));      // 8 then 16 cycles
    cyc(9);
    chk("R8 masked irq stays low", 32'(irq_o), 0);
    rd(12'h008, d); chk("R8 pending visible while masked", d, 32'h1);
    cyc(30);
    chk("R8 reset delay runs while masked", 32'(rst_seen - r0), 1);
    wr(12'h000, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(12'h000, cv(1, 1, 0, 0, 0));
    cyc(9);
    chk("R6 irq before stop", 32'(irq_o), 1);
    wr(12'h000, cv(0, 1, 0, 0, 0));
    cyc(1);
    chk("R6 stop clears irq", 32'(irq_o), 0);
    rd(12'h008, d); chk("R6 stop clears pending", d, 0);
    cyc(20);
    chk("R6 no expiry while stopped", 32'(irq_o), 0);
    wr(12'h000, cv(1, 1, 0, 0, 0));
    cyc(7); chk("R6 fresh delay after restart (early)", 32'(irq_o), 0);
    cyc(1); chk("R6 fresh delay after restart (on time)", 32'(irq_o), 1);
    wr(12'h000, 0);
  endtask

  task automatic t_reselect();
    wr(12'h000, cv(1, 1, 0, 2, 0));      // 32 cycles
    wr(12'h000, cv(1, 1, 0, 0, 0));      // ask for 8 while running
    cyc(5);  chk("R7 new select not used yet", 32'(irq_o), 0);
    cyc(24); chk("R7 old delay kept (early)", 32'(irq_o), 0);
    cyc(1);  chk("R7 old delay kept (on time)", 32'(irq_o), 1);
    service();
    cyc(7);  chk("R7 new select after restart (early)", 32'(irq_o), 0);
    cyc(1);  chk("R7 new select after restart (on time)", 32'(irq_o), 1);
    wr(12'h000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_expiry();
    t_kick();
    t_badseq();
    t_irq_masked();
    t_stop();
    t_reselect();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule